// File: doc/BRIEF.md
# Burst memory test sequencer

This block drives an external word-addressed memory through a generic controller port and checks, without end, that what it writes comes back intact. Each burst is written first and then read back from the same start address. Every returned word is compared, in order, against a value the block generates again for that word. A mismatch produces a one-cycle error record and adds to a cumulative count, and the test carries on.

The schedule is fixed. A round consists of seven data passes: five constant patterns, then two pseudo-random passes. Every pass runs eight bursts whose lengths are, in order, 1, 2, 3, 4, 5, 16, 63 and 512 words. After each burst the start address moves forward by the burst length, modulo the memory size. Status outputs show the round, the pattern and the burst length so that a separate formatter can report progress.

Top module: `bmt_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, the block offers a write command (`cmd_valid`=1, `cmd_write`=1) with `cmd_addr`=0 and `cmd_len`=1. In that state `stat_round`=0, `stat_pat`=0, `stat_len`=1, `err_count`=0, and `err_strobe`, `wr_valid` and `rd_ready` are 0.
- R2: Commands alternate between write (`cmd_write`=1) and read (`cmd_write`=0). Each read repeats the address and length of the write before it. Bursts in a pass have lengths 1,2,3,4,5,16,63,512 in that order, and passes run with `stat_pat` 0 through 6 in order. `stat_pat` and `stat_len` show the burst being commanded.
- R3: A command is accepted only on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the command stays offered with unchanged address, length and direction.
- R4: For `stat_pat` 0..4, every written word is 0x0000, 0xFF00, 0xAA55, 0xCC33 or 0xF00F respectively. A word is transferred only on a cycle where `wr_valid` and `wr_ready` are both high, and `wr_data` holds while `wr_ready` is low.
- R5: For `stat_pat` 5 and 6, the data is the state of a 16-bit LFSR. The word equals the current state, and the state then advances by shifting right and XORing 0xB400 when the bit shifted out was 1. The state is loaded with `SEED_A` when pass 5 begins and with `SEED_B` when pass 6 begins, and it carries on from burst to burst within a pass. Each readback regenerates the same sequence that was written.
- R6: After each burst the start address advances by the burst length modulo `MEM_WORDS`. A word's address is the burst start plus its index, modulo `MEM_WORDS`.
- R7: When a read word differs from its expected value, `err_strobe` is high for exactly the one cycle after that read handshake. In that cycle `err_addr` shows the word's address, `err_expect` the expected word and `err_got` the received word. The schedule continues unchanged.
- R8: `err_count` rises by exactly one for each mismatched word. It is never cleared except by reset.
- R9: `stat_round` increments when the last read word of the 512-word burst of pattern 6 is accepted. The next burst then starts at pattern 0 with length 1.
- R10: `rd_ready` is high only between the acceptance of a read command and the acceptance of that burst's last read word. A read word is consumed only when `rd_valid` and `rd_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Controller accepts command |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | output | ADDR_W | Burst start word address |
| cmd_len | output | 10 | Burst length in words |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Controller takes write word |
| wr_data | output | 16 | Write word |
| rd_valid | input | 1 | Read word present |
| rd_ready | output | 1 | Sequencer takes read word |
| rd_data | input | 16 | Read word |
| stat_round | output | ROUND_W | Completed round count |
| stat_pat | output | 3 | Current pattern pass index |
| stat_len | output | 10 | Current burst length |
| err_count | output | 32 | Cumulative mismatch count |
| err_strobe | output | 1 | One-cycle error record valid |
| err_addr | output | ADDR_W | Address of the mismatched word |
| err_expect | output | 16 | Expected word |
| err_got | output | 16 | Received word |

## Verification
The riskiest coincidence is an error record landing on the same clock edge as the schedule's wrap from the last random pass into a new round. On that edge the counters, address and seed all move while the compare still needs the old word address and expected value. The bench corrupts the final word of the 512-word burst of pattern 6 in round 0. It then expects a record naming that word's address and value, followed by a next write command at pattern 0, length 1, round 1. Single-word bursts and bursts that straddle the end of the address space are also corrupted, alongside random bit flips under random ready/valid stalls.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
   localparam int DW        = 16;
   localparam int LEN_W     = 10;
   localparam int PAT_W     = 3;
   localparam int LIDX_W    = 3;
   localparam int NUM_PAT   = 7;
   localparam int NUM_LEN   = 8;
   localparam int FIRST_RND = 5;

   typedef enum logic [1:0] {
      PH_WCMD = 2'd0,
      PH_WDAT = 2'd1,
      PH_RCMD = 2'd2,
      PH_RDAT = 2'd3
   } phase_t;

   function automatic logic [DW-1:0] fixed_word(input logic [PAT_W-1:0] p);
      case (p)
         3'd0:    return 16'h0000;
         3'd1:    return 16'hFF00;
         3'd2:    return 16'hAA55;
         3'd3:    return 16'hCC33;
         default: return 16'hF00F;
      endcase
   endfunction

   function automatic logic [LEN_W-1:0] len_of(input logic [LIDX_W-1:0] i);
      case (i)
         3'd0:    return 10'd1;
         3'd1:    return 10'd2;
         3'd2:    return 10'd3;
         3'd3:    return 10'd4;
         3'd4:    return 10'd5;
         3'd5:    return 10'd16;
         3'd6:    return 10'd63;
         default: return 10'd512;
      endcase
   endfunction

   function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction
endpackage

// File: rtl/bmt_addr_wrap.sv
module bmt_addr_wrap
   import bmt_pkg::*;
#(
   parameter int MEM_WORDS = 4096,
   parameter int ADDR_W    = 12
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [LEN_W-1:0]  b,
   output logic [ADDR_W-1:0] y
);
   localparam int SUM_W = ADDR_W + 1;

   if (MEM_WORDS < 512) begin : g_chk_size
      $error("bmt_addr_wrap: MEM_WORDS must be at least 512");
   end

   if (MEM_WORDS == (1 << ADDR_W)) begin : g_pow2
      assign y = a + ADDR_W'(b);
   end else begin : g_generic
      logic [SUM_W-1:0] sum;
      assign sum = SUM_W'(a) + SUM_W'(b);
      assign y   = (sum >= SUM_W'(MEM_WORDS)) ? ADDR_W'(sum - SUM_W'(MEM_WORDS))
                                              : sum[ADDR_W-1:0];
   end
endmodule

// File: rtl/bmt_schedule.sv
module bmt_schedule
   import bmt_pkg::*;
#(
   parameter int MEM_WORDS = 4096,
   parameter int ADDR_W    = 12,
   parameter int ROUND_W   = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               adv,
   output logic [PAT_W-1:0]   pat,
   output logic [LEN_W-1:0]   len,
   output logic [ADDR_W-1:0]  base,
   output logic [ROUND_W-1:0] round,
   output logic               pass_last
);
   logic [LIDX_W-1:0] lidx;
   logic [ADDR_W-1:0] base_next;

   if (ROUND_W < 1) begin : g_chk_round
      $error("bmt_schedule: ROUND_W must be positive");
   end

   assign len       = len_of(lidx);
   assign pass_last = (lidx == LIDX_W'(NUM_LEN - 1));

   bmt_addr_wrap #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) u_base_wrap (
      .a(base), .b(len), .y(base_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pat   <= '0;
         lidx  <= '0;
         base  <= '0;
         round <= '0;
      end else if (adv) begin
         base <= base_next;
         if (pass_last) begin
            lidx <= '0;
            if (pat == PAT_W'(NUM_PAT - 1)) begin
               pat   <= '0;
               round <= round + 1'b1;
            end else begin
               pat <= pat + 1'b1;
            end
         end else begin
            lidx <= lidx + 1'b1;
         end
      end
   end

   AST_PAT_RANGE: assert property (@(posedge clk) disable iff (rst)
      pat < PAT_W'(NUM_PAT)); // R2
   AST_BASE_RANGE: assert property (@(posedge clk) disable iff (rst)
      base < ADDR_W'(MEM_WORDS) || MEM_WORDS == (1 << ADDR_W)); // R6
   AST_ROUND_STEP: assert property (@(posedge clk) disable iff (rst)
      round != $past(round) |-> $past(pat) == PAT_W'(NUM_PAT - 1) && $past(pass_last)); // R9
endmodule

// File: rtl/bmt_datagen.sv
module bmt_datagen
   import bmt_pkg::*;
#(
   parameter logic [DW-1:0] SEED_A = 16'hACE1,
   parameter logic [DW-1:0] SEED_B = 16'h1D0F
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PAT_W-1:0] pat,
   input  logic             save,
   input  logic             restore,
   input  logic             step,
   input  logic             load,
   input  logic             load_second,
   output logic [DW-1:0]    word
);
   logic [DW-1:0] lfsr, seed_q;
   logic          rnd;

   if (SEED_A == '0 || SEED_B == '0) begin : g_chk_seed
      $error("bmt_datagen: seeds must be nonzero");
   end

   assign rnd  = (pat >= PAT_W'(FIRST_RND));
   assign word = rnd ? lfsr : fixed_word(pat);

   always_ff @(posedge clk) begin
      if (rst) begin
         lfsr   <= SEED_A;
         seed_q <= SEED_A;
      end else if (load) begin
         lfsr <= load_second ? SEED_B : SEED_A;
      end else if (restore) begin
         lfsr <= seed_q;
      end else begin
         if (save)
            seed_q <= lfsr;
         if (step && rnd)
            lfsr <= lfsr_step(lfsr);
      end
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
      lfsr != '0); // R5
   AST_REWIND: assert property (@(posedge clk) disable iff (rst)
      restore && !load |=> lfsr == $past(seed_q)); // R5
endmodule

// File: rtl/bmt_compare.sv
module bmt_compare
   import bmt_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int ERR_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [DW-1:0]     got,
   input  logic [DW-1:0]     expect_w,
   input  logic [ADDR_W-1:0] addr,
   output logic              err_strobe,
   output logic [ADDR_W-1:0] err_addr,
   output logic [DW-1:0]     err_expect,
   output logic [DW-1:0]     err_got,
   output logic [ERR_W-1:0]  err_count
);
   logic miss;
   assign miss = fire && (got != expect_w);

   always_ff @(posedge clk) begin
      if (rst) begin
         err_strobe <= 1'b0;
         err_addr   <= '0;
         err_expect <= '0;
         err_got    <= '0;
         err_count  <= '0;
      end else begin
         err_strobe <= miss;
         if (miss) begin
            err_addr   <= addr;
            err_expect <= expect_w;
            err_got    <= got;
            if (err_count != '1)
               err_count <= err_count + 1'b1;
         end
      end
   end

   AST_ERR_MONO: assert property (@(posedge clk) disable iff (rst)
      err_count >= $past(err_count)); // R8
   AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
      err_strobe && $past(err_count) != '1 |-> err_count == $past(err_count) + 1'b1); // R8
   AST_ERR_FIELDS: assert property (@(posedge clk) disable iff (rst)
      err_strobe |-> err_got != err_expect); // R7
endmodule

// File: rtl/bmt_seq.sv
module bmt_seq
   import bmt_pkg::*;
#(
   parameter int            MEM_WORDS = 4096,
   parameter int            ROUND_W   = 16,
   parameter int            ERR_W     = 32,
   parameter logic [DW-1:0] SEED_A    = 16'hACE1,
   parameter logic [DW-1:0] SEED_B    = 16'h1D0F,
   localparam int           ADDR_W    = $clog2(MEM_WORDS)
) (
   input  logic               clk,
   input  logic               rst,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic               cmd_write,
   output logic [ADDR_W-1:0]  cmd_addr,
   output logic [LEN_W-1:0]   cmd_len,
   output logic               wr_valid,
   input  logic               wr_ready,
   output logic [DW-1:0]      wr_data,
   input  logic               rd_valid,
   output logic               rd_ready,
   input  logic [DW-1:0]      rd_data,
   output logic [ROUND_W-1:0] stat_round,
   output logic [PAT_W-1:0]   stat_pat,
   output logic [LEN_W-1:0]   stat_len,
   output logic [ERR_W-1:0]   err_count,
   output logic               err_strobe,
   output logic [ADDR_W-1:0]  err_addr,
   output logic [DW-1:0]      err_expect,
   output logic [DW-1:0]      err_got
);
   phase_t            phase;
   logic [LEN_W-1:0]  word_cnt, len;
   logic [ADDR_W-1:0] base_addr, cur_addr, cur_next;
   logic [PAT_W-1:0]  pat;
   logic [DW-1:0]     gen_word;
   logic              cmd_fire, wr_fire, rd_fire, last_word, adv, pass_last;
   logic              seed_load;

   if (ERR_W < 1) begin : g_chk_err
      $error("bmt_seq: ERR_W must be positive");
   end

   assign cmd_valid = (phase == PH_WCMD) || (phase == PH_RCMD);
   assign cmd_write = (phase == PH_WCMD);
   assign cmd_addr  = base_addr;
   assign cmd_len   = len;
   assign wr_valid  = (phase == PH_WDAT);
   assign wr_data   = gen_word;
   assign rd_ready  = (phase == PH_RDAT);
   assign stat_pat  = pat;
   assign stat_len  = len;

   assign cmd_fire  = cmd_valid && cmd_ready;
   assign wr_fire   = wr_valid && wr_ready;
   assign rd_fire   = rd_ready && rd_valid;
   assign last_word = (word_cnt == len - 1'b1);
   assign adv       = rd_fire && last_word;
   assign seed_load = adv && pass_last &&
                      (pat == PAT_W'(FIRST_RND - 1) || pat == PAT_W'(FIRST_RND));

   bmt_schedule #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W), .ROUND_W(ROUND_W)) u_sched (
      .clk(clk), .rst(rst), .adv(adv),
      .pat(pat), .len(len), .base(base_addr), .round(stat_round), .pass_last(pass_last)
   );

   bmt_addr_wrap #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) u_word_wrap (
      .a(cur_addr), .b(LEN_W'(1)), .y(cur_next)
   );

   bmt_datagen #(.SEED_A(SEED_A), .SEED_B(SEED_B)) u_gen (
      .clk(clk), .rst(rst), .pat(pat),
      .save(cmd_fire && cmd_write), .restore(cmd_fire && !cmd_write),
      .step(wr_fire || rd_fire), .load(seed_load),
      .load_second(pat == PAT_W'(FIRST_RND)), .word(gen_word)
   );

   bmt_compare #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_cmp (
      .clk(clk), .rst(rst), .fire(rd_fire), .got(rd_data), .expect_w(gen_word),
      .addr(cur_addr), .err_strobe(err_strobe), .err_addr(err_addr),
      .err_expect(err_expect), .err_got(err_got), .err_count(err_count)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_WCMD;
         word_cnt <= '0;
         cur_addr <= '0;
      end else begin
         unique case (phase)
            PH_WCMD, PH_RCMD: if (cmd_fire) begin
               phase    <= (phase == PH_WCMD) ? PH_WDAT : PH_RDAT;
               word_cnt <= '0;
               cur_addr <= base_addr;
            end
            PH_WDAT: if (wr_fire) begin
               if (last_word) phase <= PH_RCMD;
               else begin
                  word_cnt <= word_cnt + 1'b1;
                  cur_addr <= cur_next;
               end
            end
            PH_RDAT: if (rd_fire) begin
               if (last_word) phase <= PH_WCMD;
               else begin
                  word_cnt <= word_cnt + 1'b1;
                  cur_addr <= cur_next;
               end
            end
            default: phase <= PH_WCMD;
         endcase
      end
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
                                  && $stable(cmd_write)); // R3
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_data)); // R4
   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cmd_valid, wr_valid, rd_ready})); // R10
   AST_WORD_BOUND: assert property (@(posedge clk) disable iff (rst)
      (wr_valid || rd_ready) |-> word_cnt < len); // R2
   AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_ready) |-> $past(cmd_valid) && !$past(cmd_write)); // R10
endmodule

// File: tb/bmt_seq_tb.sv
`timescale 1ns/1ps
module bmt_seq_tb;
   localparam int MEM = 1000;
   localparam int AW  = $clog2(MEM);
   localparam logic [15:0] SA = 16'hACE1;
   localparam logic [15:0] SB = 16'h1D0F;

   logic clk = 1'b0;
   logic rst;
   logic cmd_valid, cmd_ready, cmd_write, wr_valid, wr_ready, rd_valid, rd_ready, err_strobe;
   logic [AW-1:0] cmd_addr, err_addr;
   logic [9:0] cmd_len, stat_len;
   logic [15:0] wr_data, rd_data, err_expect, err_got;
   logic [7:0] stat_round;
   logic [2:0] stat_pat;
   logic [31:0] err_count;

   always #2 clk = ~clk;

   bmt_seq #(.MEM_WORDS(MEM), .ROUND_W(8), .SEED_A(SA), .SEED_B(SB)) u_dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .stat_round(stat_round), .stat_pat(stat_pat), .stat_len(stat_len),
      .err_count(err_count), .err_strobe(err_strobe), .err_addr(err_addr),
      .err_expect(err_expect), .err_got(err_got)
   );

   int n_chk = 0, n_bad = 0;
   logic [15:0] mem [0:MEM-1];
   int m_round, m_pat, m_lidx, m_base, wcnt, rcnt, exp_cnt, coincide_seen;
   bit m_wr, rd_active, pend, hold_pend, h_w;
   logic [15:0] m_lfsr, m_seed, p_exp, p_got;
   int p_addr, h_addr, h_len;

   function automatic int len_tb(input int i);
      case (i)
         0: return 1; 1: return 2; 2: return 3; 3: return 4;
         4: return 5; 5: return 16; 6: return 63; default: return 512;
      endcase
   endfunction

   function automatic logic [15:0] fix_tb(input int p);
      case (p)
         0: return 16'h0000; 1: return 16'hFF00; 2: return 16'hAA55;
         3: return 16'hCC33; default: return 16'hF00F;
      endcase
   endfunction

   function automatic logic [15:0] next_tb(input logic [15:0] s);
      logic [15:0] t;
      t = s >> 1;
      if (s[0]) t = t ^ 16'hB400;
      return t;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model_word();
      return (m_pat < 5) ? fix_tb(m_pat) : m_lfsr;
   endfunction

   task automatic model_reset();
      m_round = 0; m_pat = 0; m_lidx = 0; m_base = 0; wcnt = 0; rcnt = 0;
      exp_cnt = 0; m_wr = 1; rd_active = 0; pend = 0; hold_pend = 0;
      m_lfsr = SA; m_seed = SA;
   endtask

   task automatic check_reset_state();
      chk(cmd_valid === 1'b1 && cmd_write === 1'b1, "R1 write cmd", {cmd_valid, cmd_write}, 2'b11);
      chk(cmd_addr === '0, "R1 addr", cmd_addr, 0);
      chk(cmd_len === 10'd1 && stat_len === 10'd1, "R1 len", cmd_len, 1);
      chk(stat_round === 8'd0 && stat_pat === 3'd0, "R1 round/pat", {stat_round, stat_pat}, 0);
      chk(err_count === 32'd0, "R1 err_count", err_count, 0);
      chk(err_strobe === 1'b0 && wr_valid === 1'b0 && rd_ready === 1'b0, "R1 idle",
          {err_strobe, wr_valid, rd_ready}, 0);
   endtask

   task automatic model_advance();
      m_base = (m_base + len_tb(m_lidx)) % MEM;
      if (m_lidx == 7) begin
         m_lidx = 0;
         if (m_pat == 4) m_lfsr = SA;
         if (m_pat == 5) m_lfsr = SB;
         if (m_pat == 6) begin m_pat = 0; m_round++; end
         else m_pat++;
      end else m_lidx++;
   endtask

   task automatic tick();
      logic [15:0] w, e;
      bit corrupt;
      int a;
      @(negedge clk);
      if (pend) begin
         chk(err_strobe === 1'b1, "R7 strobe", err_strobe, 1);
         chk(err_addr === AW'(p_addr), "R7 addr", err_addr, p_addr);
         chk(err_expect === p_exp, "R7 expected field", err_expect, p_exp);
         chk(err_got === p_got, "R7 received field", err_got, p_got);
         chk(err_count === exp_cnt, "R8 count", err_count, exp_cnt);
      end else begin
         chk(err_strobe === 1'b0, "R7 no spurious strobe", err_strobe, 0);
      end
      pend = 0;
      if (hold_pend)
         chk(cmd_valid === 1'b1 && cmd_addr === AW'(h_addr) && cmd_len === 10'(h_len)
             && cmd_write === h_w, "R3 command held", cmd_addr, h_addr);
      if (!rd_active) chk(rd_ready === 1'b0, "R10 rd_ready outside read", rd_ready, 0);

      cmd_ready = ($urandom % 4) != 0;
      wr_ready  = ($urandom % 4) != 0;
      if (rd_active) begin
         a = (m_base + rcnt) % MEM;
         w = mem[a];
         corrupt = ($urandom % 700) == 0;
         if (m_round == 0 && m_pat == 6 && m_lidx == 7 && rcnt == 511) corrupt = 1;
         if (m_round == 1 && m_pat == 0 && m_lidx == 0) corrupt = 1;
         if (m_round == 1 && m_pat == 2 && a == MEM - 1) corrupt = 1;
         rd_valid = ($urandom % 4) != 0;
         rd_data  = corrupt ? (w ^ (16'h1 << ($urandom % 16))) : w;
      end else begin
         rd_valid = 1'b0;
         rd_data  = 16'($urandom);
      end
      #1;
      hold_pend = cmd_valid && !cmd_ready;
      h_addr = int'(cmd_addr); h_len = int'(cmd_len); h_w = cmd_write;

      if (cmd_valid && cmd_ready) begin
         chk(cmd_write === m_wr, "R2 direction", cmd_write, m_wr);
         chk(cmd_addr === AW'(m_base), "R6 start address", cmd_addr, m_base);
         chk(cmd_len === 10'(len_tb(m_lidx)), "R2 burst length", cmd_len, len_tb(m_lidx));
         chk(stat_pat === 3'(m_pat) && stat_len === 10'(len_tb(m_lidx)), "R2 status",
             {stat_pat, stat_len}, {3'(m_pat), 10'(len_tb(m_lidx))});
         chk(stat_round === 8'(m_round), "R9 round", stat_round, m_round);
         if (m_round == 1 && m_pat == 0 && m_lidx == 0 && m_wr) coincide_seen++;
         if (m_wr) begin m_seed = m_lfsr; wcnt = 0; end
         else begin m_lfsr = m_seed; rcnt = 0; rd_active = 1; end
         m_wr = !m_wr;
      end
      if (wr_valid && wr_ready) begin
         e = model_word();
         chk(wr_data === e, (m_pat < 5) ? "R4 fixed data" : "R5 random data", wr_data, e);
         mem[(m_base + wcnt) % MEM] = e;
         if (m_pat >= 5) m_lfsr = next_tb(m_lfsr);
         wcnt++;
      end
      if (rd_valid && rd_ready) begin
         e = model_word();
         if (rd_data !== e) begin
            pend = 1; p_addr = (m_base + rcnt) % MEM; p_exp = e; p_got = rd_data;
            exp_cnt++;
         end
         if (m_pat >= 5) m_lfsr = next_tb(m_lfsr);
         rcnt++;
         if (rcnt == len_tb(m_lidx)) begin
            rd_active = 0;
            model_advance();
         end
      end
   endtask

   initial begin
      int cyc;
      void'($urandom(32'd20240611));
      rst = 1'b1; cmd_ready = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
      coincide_seen = 0;
      model_reset();
      repeat (3) @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      cyc = 0;
      while (!(m_round == 2 && m_lidx == 3) && cyc < 150000) begin
         tick(); cyc++;
      end
      chk(cyc < 150000, "R9 progress to round 2 (watchdog)", cyc, 150000);
      chk(exp_cnt > 0 && err_count === exp_cnt, "R8 cumulative count", err_count, exp_cnt);
      chk(coincide_seen == 1, "R9 wrap after error on last word", coincide_seen, 1);
      @(negedge clk);
      rst = 1'b1; cmd_ready = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_state();
      model_reset();
      rst = 1'b0;
      cyc = 0;
      while (m_pat != 1 && cyc < 20000) begin
         tick(); cyc++;
      end
      chk(cyc < 20000, "R2 restart after reset (watchdog)", cyc, 20000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule